// File: doc/BRIEF.md
# Subfield Shift-In Unit

This unit is one datapath step for an execution core. It takes a destination word and a source word. It picks one subfield of the source: a nibble, a byte or a half-word, chosen by an index carried in the opcode. It then shifts the destination by the width of that subfield and drops the subfield into the end that the shift left empty. The left form shifts toward the top and fills the lowest bits. The right form shifts toward the bottom and fills the highest bits. Bits pushed past the far end are thrown away; nothing wraps around.

An operation is issued by raising `opValid` for one cycle with the opcode fields and operands present. One clock later the registered result appears on `resOut`, and `doneOut` is high for that cycle. The result stays put until the next issued operation. Back-to-back issue on consecutive cycles is allowed, with one result per cycle.

Top module: `shin_unit`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `resOut` is 0 and `doneOut` is 0.
- R2: `doneOut` is high in exactly those cycles that follow a cycle in which `opValid` was sampled high at the rising clock edge.
- R3: Size code 2'b00 (nibble), direction 0 (left) gives {dst[27:0], src[4*i+3:4*i]} with i = index[2:0]. For example, dst 0x01234567 with src 0x00000008 and index 0 gives 0x12345678.
- R4: Size code 2'b01 (byte), direction 0 gives {dst[23:0], src[8*i+7:8*i]} with i = index[1:0].
- R5: Size code 2'b10 (half-word), direction 0 gives {dst[15:0], src[16*i+15:16*i]} with i = index[0].
- R6: Direction 1 (right) places the selected subfield in the top bits. With the same subfield and index rules as R3, R4 and R5, the result is {field, dst[31:4]}, {field, dst[31:8]} or {field, dst[31:16]}.
- R7: Only the low log2(count) index bits take part in the selection: index bit 2 has no effect for bytes, and index bits 2:1 have no effect for half-words.
- R8: Size code 2'b11 is reserved. It loads the destination unchanged into `resOut`, whatever the direction and index.
- R9: When `opValid` is low, `resOut` keeps its value whatever the other inputs do.
- R10: Destination bits shifted past the word edge are discarded. For example, a left nibble shift of 0xFFFFFFFF with a zero source gives 0xFFFFFFF0, and a right nibble shift gives 0x0FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Issue strobe, one operation per high cycle |
| opSize | input | 2 | Subfield size: 00 nibble, 01 byte, 10 half-word, 11 pass-through |
| opDir | input | 1 | 0 shifts left and fills the bottom, 1 shifts right and fills the top |
| opIndex | input | 3 | Subfield number within the source |
| dstIn | input | 32 | Destination operand |
| srcIn | input | 32 | Source operand |
| resOut | output | 32 | Registered result |
| doneOut | output | 1 | High one clock after an issue |

## Verification
The bench sweeps every size code, direction and index value over fixed and pseudo-random operands, so each subfield position is covered. A unit that sliced the wrong subfield, or that rotated the spilled bits back in instead of dropping them, would disagree with the arithmetic model. Index values above the subfield count are included. A decoder that used the full index would then pick a bit range outside the source, or the wrong half. Inputs are also changed while no issue is pending, and two operations are issued back-to-back. These catch a result register that loads without an issue, and a done pulse that is stretched, missing or one clock late. Pass-through on the reserved size code is checked in both directions.

// File: rtl/shin_pkg.sv
package shin_pkg;

  typedef enum logic [1:0] {
    SZ_NIB  = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_RSVD = 2'b11
  } sizeSel_t;

  typedef struct packed {
    logic     capture;
    logic     passThru;
    logic     goRight;
    sizeSel_t size;
  } ctlStrobe_t;

endpackage

// File: rtl/shin_ctrl.sv
module shin_ctrl
  import shin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opSize,
  input  logic       opDir,
  output ctlStrobe_t strobe,
  output logic       doneOut
);

  sizeSel_t sizeDec;

  always_comb begin
    sizeDec = sizeSel_t'(opSize);
    strobe.capture  = opValid;
    strobe.passThru = (sizeDec == SZ_RSVD);
    strobe.goRight  = opDir;
    strobe.size     = sizeDec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneOut <= 1'b0;
    else       doneOut <= opValid;
  end

endmodule

// File: rtl/shin_datapath.sv
module shin_datapath
  import shin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [IDX_W-1:0]  opIndex,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] srcIn,
  output logic [DATA_W-1:0] resOut
);

  localparam int N_SIZES = 3;
  localparam int NIB_W   = DATA_W / 8;
  localparam int HALF_W  = DATA_W / 2;

  logic [DATA_W-1:0] leftRes  [N_SIZES];
  logic [DATA_W-1:0] rightRes [N_SIZES];
  logic [DATA_W-1:0] nextRes;

  for (genvar g = 0; g < N_SIZES; g++) begin : gSize
    localparam int FW   = NIB_W << g;
    localparam int FC   = DATA_W / FW;
    localparam int SELW = $clog2(FC);

    logic [SELW-1:0] selIdx;
    logic [FW-1:0]   field;

    always_comb begin
      selIdx = opIndex[SELW-1:0];
      field  = srcIn[int'(selIdx)*FW +: FW];
    end

    assign leftRes[g]  = {dstIn[DATA_W-FW-1:0], field};
    assign rightRes[g] = {field, dstIn[DATA_W-1:FW]};
  end

  always_comb begin
    nextRes = dstIn;
    if (!strobe.passThru) begin
      if (strobe.goRight) nextRes = rightRes[strobe.size];
      else                nextRes = leftRes[strobe.size];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               resOut <= '0;
    else if (strobe.capture) resOut <= nextRes;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.capture) |-> $stable(resOut)); // R9

  AST_RSVD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capture && strobe.passThru) |-> resOut == $past(dstIn)); // R8

  AST_NIB_LEFT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capture && strobe.size == SZ_NIB && !strobe.goRight)
    |-> resOut[DATA_W-1:NIB_W] == $past(dstIn[DATA_W-NIB_W-1:0])); // R10

  AST_HALF_RIGHT_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capture && strobe.size == SZ_HALF && strobe.goRight)
    |-> resOut[HALF_W-1:0] == $past(dstIn[DATA_W-1:HALF_W])); // R6

endmodule

// File: rtl/shin_unit.sv
module shin_unit
  import shin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opSize,
  input  logic              opDir,
  input  logic [IDX_W-1:0]  opIndex,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] srcIn,
  output logic [DATA_W-1:0] resOut,
  output logic              doneOut
);

  ctlStrobe_t strobe;

  shin_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opSize  (opSize),
    .opDir   (opDir),
    .strobe  (strobe),
    .doneOut (doneOut)
  );

  shin_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opIndex (opIndex),
    .dstIn   (dstIn),
    .srcIn   (srcIn),
    .resOut  (resOut)
  );

  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid) |-> doneOut); // R2

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(opValid) |-> !doneOut); // R2

endmodule

// File: tb/sim_shin_unit.sv
module sim_shin_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opSize = '0;
  logic        opDir = 1'b0;
  logic [2:0]  opIndex = '0;
  logic [31:0] dstIn = '0;
  logic [31:0] srcIn = '0;
  logic [31:0] resOut;
  logic        doneOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  shin_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSize(opSize), .opDir(opDir),
    .opIndex(opIndex), .dstIn(dstIn), .srcIn(srcIn), .resOut(resOut), .doneOut(doneOut)
  );

  function automatic logic [31:0] model(input logic [1:0] sz, input logic dr,
                                        input logic [2:0] ix, input logic [31:0] d,
                                        input logic [31:0] s);
    int w, cnt, k;
    logic [31:0] mask, fld;
    if (sz == 2'b11) return d;
    w    = 4 * (1 << sz);
    cnt  = 32 / w;
    k    = ix % cnt;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    fld  = (s >> (w * k)) & mask;
    if (!dr) return (d << w) | fld;
    return (d >> w) | (fld << (32 - w));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [1:0] sz, input logic dr);
    if (sz == 2'b11) return "R8";
    if (dr) return "R6";
    case (sz)
      2'b00:   return "R3";
      2'b01:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic issue(input logic [1:0] sz, input logic dr, input logic [2:0] ix,
                       input logic [31:0] d, input logic [31:0] s, input string tag);
    @(negedge clk);
    opSize = sz; opDir = dr; opIndex = ix; dstIn = d; srcIn = s; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    check({tag, " done"}, {31'd0, doneOut}, 32'd1);
    check(tag, resOut, model(sz, dr, ix, d, s));
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset result", resOut, 32'd0);
    check("R1 reset done", {31'd0, doneOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset result", resOut, 32'd0);
    check("R1 post-reset done", {31'd0, doneOut}, 32'd0);

    issue(2'b00, 1'b0, 3'd0, 32'h0123_4567, 32'h0000_0008, "R3 example");
    check("R3 example value", resOut, 32'h1234_5678);
    issue(2'b00, 1'b0, 3'd0, 32'hFFFF_FFFF, 32'h0, "R10 left drop");
    check("R10 left value", resOut, 32'hFFFF_FFF0);
    issue(2'b00, 1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0, "R10 right drop");
    check("R10 right value", resOut, 32'h0FFF_FFFF);

    for (int p = 0; p < 5; p++) begin
      logic [31:0] d, s;
      case (p)
        0: begin d = 32'h0123_4567; s = 32'h89AB_CDEF; end
        1: begin d = 32'hFFFF_FFFF; s = 32'h0000_0000; end
        2: begin d = 32'h0000_0000; s = 32'hFFFF_FFFF; end
        default: begin
          seed = nextRand(seed); d = seed;
          seed = nextRand(seed); s = seed;
        end
      endcase
      for (int sz = 0; sz < 4; sz++)
        for (int dr = 0; dr < 2; dr++)
          for (int ix = 0; ix < 8; ix++) begin
            string tg;
            tg = reqOf(sz[1:0], dr[0]);
            if (ix >= 2 && sz == 2) tg = "R7";
            if (ix >= 4 && sz == 1) tg = "R7";
            issue(sz[1:0], dr[0], ix[2:0], d, s, tg);
          end
    end

    // R7 explicit alias: byte index 5 equals index 1
    issue(2'b01, 1'b0, 3'd5, 32'h0, 32'h4433_2211, "R7 byte alias");
    check("R7 byte alias value", resOut, 32'h0000_0022);
    issue(2'b10, 1'b1, 3'd6, 32'h0, 32'hBEEF_CAFE, "R7 half alias");
    check("R7 half alias value", resOut, 32'hCAFE_0000);

    // R9 hold with changing inputs and no issue
    held = resOut;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      opSize = c[1:0]; opDir = c[0]; opIndex = c[2:0];
      dstIn = ~dstIn; srcIn = srcIn + 32'h1111;
    end
    @(negedge clk);
    check("R9 hold", resOut, held);
    check("R2 idle done low", {31'd0, doneOut}, 32'd0);

    // R2 back-to-back issue
    @(negedge clk);
    opSize = 2'b01; opDir = 1'b0; opIndex = 3'd2; dstIn = 32'hAABB_CCDD;
    srcIn = 32'h1234_5678; opValid = 1'b1;
    @(negedge clk);
    check("R2 b2b first done", {31'd0, doneOut}, 32'd1);
    check("R4 b2b first", resOut, 32'hBBCC_DD34);
    opSize = 2'b11; dstIn = 32'h5A5A_0F0F;
    @(negedge clk);
    opValid = 1'b0;
    check("R2 b2b second done", {31'd0, doneOut}, 32'd1);
    check("R8 b2b second", resOut, 32'h5A5A_0F0F);
    @(negedge clk);
    check("R2 done drops", {31'd0, doneOut}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule